// File: doc/BRIEF.md
# Delegated Interrupt Enable CSR Unit

This unit keeps the machine-level interrupt state of one hardware thread: an enable word, a pending word and a delegation word. Each bit stands for one interrupt source. Setting a delegation bit hands that source to the supervisor level, so the source is taken without entering machine mode. The unit has no storage for the supervisor-level enable and pending registers. They are windows onto the machine words, filtered by the delegation mask. Writes through those windows reach only the delegated bit positions.

Accesses use a simple register port: a write strobe, a 12-bit address, 64-bit write data and combinational 64-bit read data. Hardware pending lines are ORed into the pending word on every cycle. The live enable, pending and delegation words are available on output pins for the interrupt logic that follows. A user trap value register sits on the same port. It only stores what is written to it and has no path into the interrupt state.

The register addresses are 0x304 (machine enable), 0x104 (supervisor enable view), 0x344 (machine pending), 0x144 (supervisor pending view), 0x303 (delegation) and 0x043 (user trap value). Only bit positions 1, 3, 5, 7, 9 and 11 exist in the interrupt words, which gives an implemented mask of 0xAAA.

Top module: `irq_deleg_csr`

## Requirements
- R1: After a synchronous active-low reset, the enable, pending, delegation and user trap value registers all read zero, and `enOut`, `pendOut` and `delegOut` are zero.
- R2: A write to 0x304 sets the enable word to wdata AND 0xAAA on the next rising edge. Bits outside 0xAAA always read zero.
- R3: A write to 0x303 sets the delegation word to wdata AND 0xAAA on the next rising edge.
- R4: A write to 0x104 sets the enable word to (old enable AND NOT deleg) OR (wdata AND deleg) on the next rising edge. Non-delegated bits keep their value.
- R5: A read of 0x104 returns enable AND deleg. Non-delegated bits read zero.
- R6: The pending word is (stored pending OR `hwIrqPend`) AND 0xAAA, and a read of 0x344 returns it. A read of 0x144 returns pending AND deleg.
- R7: A write to 0x344 sets the stored pending bits to wdata AND 0xAAA. A write to 0x144 changes only the delegated stored pending bits, using the same merge as R4.
- R8: A write to 0x043 stores all 64 bits, which read back unchanged. Such a write never changes the enable, pending or delegation words.
- R9: Reads of any address other than the six above return zero. Writes to such an address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Synchronous active-low reset |
| csrWe | input | 1 | Write strobe for the current address |
| csrAddr | input | 12 | Register address |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Combinational read data for csrAddr |
| hwIrqPend | input | 64 | Hardware interrupt pending lines |
| enOut | output | 64 | Current machine enable word |
| pendOut | output | 64 | Current effective pending word |
| delegOut | output | 64 | Current delegation word |

## Verification
Read data is combinational, so a read result is due in the same cycle as its address. Every register update is due one rising edge after its write strobe. Changes to `hwIrqPend` appear on `pendOut` and in the pending reads with no delay. The bench drives all inputs at the falling edge. For each write it lets exactly one rising edge pass with the strobe high, drops the strobe, and then samples the reads one nanosecond after the following falling edge. The sweep walks through all 64 delegation patterns on the implemented bits, and for each pattern it models the expected words arithmetically.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

  localparam int unsigned XLEN   = 64;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADR_MEN   = 12'h304;
  localparam logic [ADDR_W-1:0] ADR_SEN   = 12'h104;
  localparam logic [ADDR_W-1:0] ADR_MPEND = 12'h344;
  localparam logic [ADDR_W-1:0] ADR_SPEND = 12'h144;
  localparam logic [ADDR_W-1:0] ADR_DELEG = 12'h303;
  localparam logic [ADDR_W-1:0] ADR_UTVAL = 12'h043;

  // Strobes from the address decoder into the register datapath
  typedef struct packed {
    logic wrMen;
    logic wrSen;
    logic wrMpend;
    logic wrSpend;
    logic wrDeleg;
    logic wrUtval;
  } csrStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MEN,
    RD_SEN,
    RD_MPEND,
    RD_SPEND,
    RD_DELEG,
    RD_UTVAL
  } rdSel_t;

  function automatic logic isKnownAddr(input logic [ADDR_W-1:0] a);
    return (a == ADR_MEN) || (a == ADR_SEN) || (a == ADR_MPEND) ||
           (a == ADR_SPEND) || (a == ADR_DELEG) || (a == ADR_UTVAL);
  endfunction

endpackage

// File: rtl/irq_csr_ctrl.sv
module irq_csr_ctrl
  import irq_csr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          csrWe,
  input  logic [AW-1:0] csrAddr,
  output csrStrobe_t    strobe,
  output rdSel_t        rdSel
);

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    case (csrAddr)
      ADR_MEN: begin
        rdSel        = RD_MEN;
        strobe.wrMen = csrWe;
      end
      ADR_SEN: begin
        rdSel        = RD_SEN;
        strobe.wrSen = csrWe;
      end
      ADR_MPEND: begin
        rdSel          = RD_MPEND;
        strobe.wrMpend = csrWe;
      end
      ADR_SPEND: begin
        rdSel          = RD_SPEND;
        strobe.wrSpend = csrWe;
      end
      ADR_DELEG: begin
        rdSel          = RD_DELEG;
        strobe.wrDeleg = csrWe;
      end
      ADR_UTVAL: begin
        rdSel          = RD_UTVAL;
        strobe.wrUtval = csrWe;
      end
      default: begin
        rdSel  = RD_NONE;
        strobe = '0;
      end
    endcase
  end

endmodule

// File: rtl/irq_csr_dp.sv
module irq_csr_dp
  import irq_csr_pkg::*;
#(
  parameter int unsigned       W         = XLEN,
  parameter logic [XLEN-1:0]   IMPL_MASK = 64'h0000_0000_0000_0AAA
) (
  input  logic         clk,
  input  logic         rstN,
  input  csrStrobe_t   strobe,
  input  rdSel_t       rdSel,
  input  logic [W-1:0] csrWdata,
  input  logic [W-1:0] hwIrqPend,
  output logic [W-1:0] csrRdata,
  output logic [W-1:0] enOut,
  output logic [W-1:0] pendOut,
  output logic [W-1:0] delegOut
);

  localparam logic [W-1:0] IMPL = IMPL_MASK[W-1:0];

  logic [W-1:0] enQ, enD;
  logic [W-1:0] pendQ, pendD;
  logic [W-1:0] delegQ, delegD;
  logic [W-1:0] utvalQ, utvalD;
  logic [W-1:0] effPend;

  assign effPend = (pendQ | hwIrqPend) & IMPL;

  // Next-state: the supervisor views merge only through the delegation mask
  always_comb begin
    enD = enQ;
    if (strobe.wrMen) begin
      enD = csrWdata & IMPL;
    end else if (strobe.wrSen) begin
      enD = (enQ & ~delegQ) | (csrWdata & delegQ);
    end
  end

  always_comb begin
    pendD = pendQ;
    if (strobe.wrMpend) begin
      pendD = csrWdata & IMPL;
    end else if (strobe.wrSpend) begin
      pendD = (pendQ & ~delegQ) | (csrWdata & delegQ);
    end
  end

  always_comb begin
    delegD = delegQ;
    if (strobe.wrDeleg) delegD = csrWdata & IMPL;
  end

  always_comb begin
    utvalD = utvalQ;
    if (strobe.wrUtval) utvalD = csrWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= '0;
      pendQ  <= '0;
      delegQ <= '0;
      utvalQ <= '0;
    end else begin
      enQ    <= enD;
      pendQ  <= pendD;
      delegQ <= delegD;
      utvalQ <= utvalD;
    end
  end

  always_comb begin
    case (rdSel)
      RD_MEN:   csrRdata = enQ;
      RD_SEN:   csrRdata = enQ & delegQ;
      RD_MPEND: csrRdata = effPend;
      RD_SPEND: csrRdata = effPend & delegQ;
      RD_DELEG: csrRdata = delegQ;
      RD_UTVAL: csrRdata = utvalQ;
      default:  csrRdata = '0;
    endcase
  end

  assign enOut    = enQ;
  assign pendOut  = effPend;
  assign delegOut = delegQ;

endmodule

// File: rtl/irq_deleg_csr.sv
module irq_deleg_csr
  import irq_csr_pkg::*;
#(
  parameter logic [XLEN-1:0] IMPL_MASK = 64'h0000_0000_0000_0AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  input  logic [XLEN-1:0]   hwIrqPend,
  output logic [XLEN-1:0]   enOut,
  output logic [XLEN-1:0]   pendOut,
  output logic [XLEN-1:0]   delegOut
);

  csrStrobe_t strobe;
  rdSel_t     rdSel;

  irq_csr_ctrl #(.AW(ADDR_W)) u_ctrl (
    .csrWe   (csrWe),
    .csrAddr (csrAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  irq_csr_dp #(.W(XLEN), .IMPL_MASK(IMPL_MASK)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .csrWdata  (csrWdata),
    .hwIrqPend (hwIrqPend),
    .csrRdata  (csrRdata),
    .enOut     (enOut),
    .pendOut   (pendOut),
    .delegOut  (delegOut)
  );

endmodule

// File: rtl/irq_deleg_csr_chk.sv
module irq_deleg_csr_chk
  import irq_csr_pkg::*;
#(
  parameter logic [XLEN-1:0] IMPL_MASK = 64'h0000_0000_0000_0AAA
) (
  input logic              clk,
  input logic              rstN,
  input logic              csrWe,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [XLEN-1:0]   csrWdata,
  input logic [XLEN-1:0]   csrRdata,
  input logic [XLEN-1:0]   hwIrqPend,
  input logic [XLEN-1:0]   enOut,
  input logic [XLEN-1:0]   pendOut,
  input logic [XLEN-1:0]   delegOut
);

  // R1: reset clears the exposed state
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (enOut == '0) && (delegOut == '0));

  // R2: unimplemented enable and delegation bits never set
  a_r2_impl_only: assert property (@(posedge clk) disable iff (!rstN)
    ((enOut & ~IMPL_MASK) == '0) && ((delegOut & ~IMPL_MASK) == '0));

  // R4: supervisor enable write merges through the delegation mask
  a_r4_sen_merge: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrAddr == ADR_SEN) |=>
      enOut == (($past(enOut) & ~$past(delegOut)) | ($past(csrWdata) & $past(delegOut))));

  // R5: supervisor enable view
  a_r5_sen_view: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == ADR_SEN) |-> csrRdata == (enOut & delegOut));

  // R6: supervisor pending view and hardware lines reach pending
  a_r6_spend_view: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == ADR_SPEND) |-> csrRdata == (pendOut & delegOut));
  a_r6_hw_visible: assert property (@(posedge clk) disable iff (!rstN)
    ((hwIrqPend & IMPL_MASK & ~pendOut) == '0));

  // R8: user trap value writes are isolated from interrupt state
  a_r8_utval_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrAddr == ADR_UTVAL) |=> $stable(enOut) && $stable(delegOut));

  // R9: unknown addresses read zero and leave state alone
  a_r9_unknown_read: assert property (@(posedge clk) disable iff (!rstN)
    !isKnownAddr(csrAddr) |-> csrRdata == '0);
  a_r9_unknown_write: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && !isKnownAddr(csrAddr)) |=> $stable(enOut) && $stable(delegOut));

endmodule

bind irq_deleg_csr irq_deleg_csr_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csrWe     (csrWe),
  .csrAddr   (csrAddr),
  .csrWdata  (csrWdata),
  .csrRdata  (csrRdata),
  .hwIrqPend (hwIrqPend),
  .enOut     (enOut),
  .pendOut   (pendOut),
  .delegOut  (delegOut)
);

// File: tb/irq_deleg_csr_test.sv
`timescale 1ns/1ps
module irq_deleg_csr_test;

  localparam logic [63:0] IMPL = 64'h0AAA;
  localparam logic [11:0] A_MEN = 12'h304, A_SEN = 12'h104, A_MPEND = 12'h344;
  localparam logic [11:0] A_SPEND = 12'h144, A_DELEG = 12'h303, A_UTVAL = 12'h043;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWe = 1'b0;
  logic [11:0] csrAddr = 12'h000;
  logic [63:0] csrWdata = '0;
  logic [63:0] csrRdata;
  logic [63:0] hwIrqPend = '0;
  logic [63:0] enOut, pendOut, delegOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  logic [63:0] mEn = '0, mPend = '0, mDel = '0, mUtv = '0;

  always #2.5 clk = ~clk;

  irq_deleg_csr uut (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .hwIrqPend(hwIrqPend),
    .enOut(enOut), .pendOut(pendOut), .delegOut(delegOut)
  );

  // place 6-bit value v on implemented positions 1,3,5,7,9,11
  function automatic logic [63:0] spread(input logic [5:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < 6; i++) r[2*i+1] = v[i];
    return r;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    csrAddr = a;
    #1;
    check(csrRdata, exp, tag);
  endtask

  function automatic logic [63:0] effPend();
    return (mPend | hwIrqPend) & IMPL;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_MEN,   64'h0, "R1 enable");
    rd(A_DELEG, 64'h0, "R1 deleg");
    rd(A_MPEND, 64'h0, "R1 pending");
    rd(A_UTVAL, 64'h0, "R1 utval");
    check(enOut | delegOut | pendOut, 64'h0, "R1 outputs");

    // R2 machine enable write masking
    wr(A_MEN, '1); mEn = IMPL;
    rd(A_MEN, mEn, "R2 all ones");
    check(enOut, mEn, "R2 enOut");
    wr(A_MEN, 64'hFFFF_FFFF_FFFF_F555); mEn = 64'h0;
    rd(A_MEN, mEn, "R2 unimplemented only");

    // R3 delegation masking
    wr(A_DELEG, '1); mDel = IMPL;
    rd(A_DELEG, mDel, "R3 all ones");
    check(delegOut, mDel, "R3 delegOut");

    // sweep every delegation pattern on the implemented bits
    for (int d = 0; d < 64; d++) begin
      logic [63:0] wd;
      logic [63:0] junk;
      wr(A_DELEG, spread(6'(d)) | 64'hF000_0000_0000_5000); mDel = spread(6'(d));
      rd(A_DELEG, mDel, "R3 sweep");

      wr(A_MEN, spread(6'((d * 5 + 3) & 63))); mEn = spread(6'((d * 5 + 3) & 63));
      wd = (d[0]) ? 64'hFFFF_FFFF_FFFF_FFFF : spread(6'((d * 7 + 1) & 63));
      wr(A_SEN, wd); mEn = (mEn & ~mDel) | (wd & mDel);
      rd(A_MEN, mEn, "R4 merge");
      rd(A_SEN, mEn & mDel, "R5 view");

      // R8 user trap value must not reach enable
      junk = {32'hDEAD_BEEF, 26'h0, 6'(d)} ^ 64'hFFFF_0000_FFFF_0FFF;
      wr(A_UTVAL, junk); mUtv = junk;
      rd(A_UTVAL, mUtv, "R8 readback");
      rd(A_MEN, mEn, "R8 enable unchanged");
      check(delegOut, mDel, "R8 deleg unchanged");

      // R6 pending with hardware lines
      hwIrqPend = spread(6'((d * 11 + 2) & 63)) | 64'h8000_0000_0001_0000;
      rd(A_MPEND, effPend(), "R6 machine pending");
      rd(A_SPEND, effPend() & mDel, "R6 supervisor pending");
      check(pendOut, effPend(), "R6 pendOut");

      // R7 pending writes
      wr(A_MPEND, spread(6'((d * 3) & 63))); mPend = spread(6'((d * 3) & 63));
      wr(A_SPEND, ~spread(6'((d * 3) & 63))); mPend = (mPend & ~mDel) | (~spread(6'((d * 3) & 63)) & mDel);
      hwIrqPend = '0;
      rd(A_MPEND, effPend(), "R7 stored pending");

      // R9 unknown addresses
      wr(12'h105, '1);
      wr(12'h7C0, '1);
      rd(A_MEN, mEn, "R9 enable unchanged");
      rd(A_MPEND, effPend(), "R9 pending unchanged");
      rd(12'h305, 64'h0, "R9 unknown read");
    end

    rd(A_UTVAL, mUtv, "R8 final readback");
    rd(12'hFFF, 64'h0, "R9 top address read");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule